// File: doc/BRIEF.md
# ADC Result Byte Formatter

This block sits between an analog-to-digital converter and a byte-wide register read port. Each finished 10-bit conversion result is captured together with its conversion type, and a ready flag is raised. Software then fetches the result as two bytes, a high byte and a low byte. The placement of the code bits within those two bytes is set by a justification setting. A signed/unsigned setting decides the content of the unused high-byte bits.

The pair is read atomically. Which byte must be read first depends on the justification: in left mode it is the high byte, and in right mode it is the low byte. Reading that first byte clears the ready flag. The same read also copies the companion byte of the same conversion into a shadow register. The second read returns that shadow, so a conversion that completes between the two reads cannot split the pair. The converter already delivers signed codes in two's complement form, so the block only places bits and fills sign bits. It does no arithmetic.

Top module: `adc_result_fmt`

## Requirements
- R1: After reset the ready flag is 0, the read data is 0x00 and the shadow byte is 0x00.
- R2: A conversion-done strobe stores the 10-bit code and its conversion type, and sets the ready flag in the next cycle. Type encoding: 0 = absolute voltage, 1 = ratiometric, 2 = temperature, 3 = treated as non-ratiometric.
- R3: With justification 0 (left), a read of the high byte (select 1) returns code bits [9:2].
- R4: With justification 0, a read of the low byte (select 0) after the high-byte read returns code bits [1:0] in bits [7:6], with bits [5:0] equal to 0.
- R5: With justification 1 (right), a read of the low byte (select 0) returns code bits [7:0]. A following high-byte read returns code bits [9:8] in bits [1:0]. When the output is unsigned, bits [7:2] of that byte are 0.
- R6: With justification 1, a ratiometric conversion and the sign setting at 1, bits [7:2] of the high byte all equal code bit 9. Code bit 9 is 1 for a negative result.
- R7: For absolute-voltage and temperature conversions, the high-byte fill bits are 0 whatever the sign setting.
- R8: Reading the first byte for the current justification clears the ready flag. Reading the other byte leaves the flag unchanged and returns the shadow byte.
- R9: A conversion that completes after a first-byte read replaces the stored code and sets the flag again. The second-byte read still returns the byte of the earlier conversion.
- R10: Read data appears in the cycle after the read strobe and holds its value while no read is made.
- R11: When a done strobe and a first-byte read fall in the same cycle, the read returns the earlier code and the ready flag stays set. The new code is the one stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Conversion finished strobe |
| code_i | input | 10 | Conversion code, valid with done_i |
| kind_i | input | 2 | Conversion type, valid with done_i |
| right_just_i | input | 1 | 0 = left-justified, 1 = right-justified |
| signed_sel_i | input | 1 | 1 = signed output for ratiometric conversions |
| rd_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | 0 = low byte, 1 = high byte |
| rd_data_o | output | 8 | Read data, one cycle after rd_i |
| ready_o | output | 1 | Result-ready interrupt flag |

## Verification
The hardest case to reach from the ports is a torn pair. It needs a new conversion to land between the first-byte and second-byte reads. The stimulus issues the first read, then fires a done strobe with a different code, and only then issues the second read. The expected byte is the one from the old code. A second hard case puts the done strobe and the first read in the same clock. The bench then expects the read to return the old code and the flag to remain set. The bench also reads the second byte with no first read before it, and checks that the flag is unchanged and the stale shadow is returned.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    KIND_ABS   = 2'd0,
    KIND_RATIO = 2'd1,
    KIND_TEMP  = 2'd2,
    KIND_RSVD  = 2'd3
  } conv_kind_e;

  localparam logic SEL_LOW  = 1'b0;
  localparam logic SEL_HIGH = 1'b1;
endpackage

// File: rtl/adc_fmt_hold.sv
module adc_fmt_hold
  import adc_fmt_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  input  conv_kind_e        kind_i,
  input  logic              take_i,
  output logic [CODE_W-1:0] code_o,
  output conv_kind_e        kind_o,
  output logic              ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      kind_o <= KIND_ABS;
    end else if (done_i) begin
      code_o <= code_i;
      kind_o <= kind_i;
    end
  end

  // new result wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ready_o <= 1'b0;
    else if (done_i)  ready_o <= 1'b1;
    else if (take_i)  ready_o <= 1'b0;
  end
endmodule

// File: rtl/adc_fmt_layout.sv
module adc_fmt_layout
  import adc_fmt_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  conv_kind_e        kind_i,
  input  logic              right_i,
  input  logic              signed_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  // requires BYTE_W < CODE_W < 2*BYTE_W
  localparam int XW  = CODE_W - BYTE_W;
  localparam int PAD = BYTE_W - XW;

  logic fill;
  assign fill = signed_i && (kind_i == KIND_RATIO) && code_i[CODE_W-1];

  always_comb begin
    if (right_i) begin
      lo_o = code_i[BYTE_W-1:0];
      hi_o = {{PAD{fill}}, code_i[CODE_W-1:BYTE_W]};
    end else begin
      hi_o = code_i[CODE_W-1:XW];
      lo_o = {code_i[XW-1:0], {PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/adc_fmt_read.sv
module adc_fmt_read
  import adc_fmt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              sel_i,
  input  logic              right_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  output logic              take_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic              first_sel;
  logic [BYTE_W-1:0] first_byte, second_byte, shadow_q;

  assign first_sel   = right_i ? SEL_LOW : SEL_HIGH;
  assign take_o      = rd_i && (sel_i == first_sel);
  assign first_byte  = right_i ? lo_i : hi_i;
  assign second_byte = right_i ? hi_i : lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (take_o) shadow_q <= second_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= take_o ? first_byte : shadow_q;
  end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_fmt_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        kind_i,
  input  logic              right_just_i,
  input  logic              signed_sel_i,
  input  logic              rd_i,
  input  logic              rd_sel_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              ready_o
);
  logic [CODE_W-1:0] held_code;
  conv_kind_e        held_kind;
  logic [BYTE_W-1:0] hi_byte, lo_byte;
  logic              take;

  adc_fmt_hold #(.CODE_W(CODE_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done_i),
    .code_i  (code_i),
    .kind_i  (conv_kind_e'(kind_i)),
    .take_i  (take),
    .code_o  (held_code),
    .kind_o  (held_kind),
    .ready_o (ready_o)
  );

  adc_fmt_layout #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_layout (
    .code_i   (held_code),
    .kind_i   (held_kind),
    .right_i  (right_just_i),
    .signed_i (signed_sel_i),
    .hi_o     (hi_byte),
    .lo_o     (lo_byte)
  );

  adc_fmt_read #(.BYTE_W(BYTE_W)) u_read (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .sel_i     (rd_sel_i),
    .right_i   (right_just_i),
    .hi_i      (hi_byte),
    .lo_i      (lo_byte),
    .take_o    (take),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/adc_result_fmt_chk.sv
module adc_result_fmt_chk #(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic [CODE_W-1:0] code_i,
  input logic [1:0]        kind_i,
  input logic              right_just_i,
  input logic              signed_sel_i,
  input logic              rd_i,
  input logic              rd_sel_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              ready_o
);
  logic [CODE_W-1:0] last_code;
  logic              first_rd, second_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_code <= '0;
    else if (done_i) last_code <= code_i;
  end

  assign first_rd  = rd_i && (rd_sel_i == !right_just_i);
  assign second_rd = rd_i && (rd_sel_i == right_just_i);

  assert_ready_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_o);

  assert_first_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_rd && !done_i |=> !ready_o);

  assert_second_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_rd && !done_i |=> ready_o == $past(ready_o));

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));

  assert_left_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_rd && !right_just_i |=> rd_data_o == $past(last_code[CODE_W-1:CODE_W-BYTE_W]));

  assert_right_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_rd && right_just_i |=> rd_data_o == $past(last_code[BYTE_W-1:0]));
endmodule

bind adc_result_fmt adc_result_fmt_chk #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/test_adc_result_fmt.sv
module test_adc_result_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done = 1'b0;
  logic [9:0] code = '0;
  logic [1:0] kind = '0;
  logic       right_just = 1'b0;
  logic       signed_sel = 1'b0;
  logic       rd = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       ready;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  adc_result_fmt i_adc_result_fmt (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .code_i(code), .kind_i(kind),
    .right_just_i(right_just), .signed_sel_i(signed_sel), .rd_i(rd),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .ready_o(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: read data lands one edge after the strobe (R10)
  always @(posedge clk) begin
    if (rd) begin
      @(negedge clk);
      if (exp_q.size() == 0) check(0, "R10 unexpected read", rd_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic conv(input logic [9:0] c, input logic [1:0] k);
    @(negedge clk);
    done = 1'b1; code = c; kind = k;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic rd_byte(input logic sel, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] hold_rd;
    repeat (2) @(negedge clk);
    check(ready == 1'b0, "R1 ready after reset", ready, 0);
    check(rd_data == 8'h00, "R1 data after reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: shadow empty, second byte in left mode is low; flag untouched
    rd_byte(1'b0, 8'h00, "R1 shadow after reset");

    // left, absolute
    conv(10'h2B5, 2'd0);
    check(ready == 1'b1, "R2 ready set", ready, 1);
    rd_byte(1'b1, 8'hAD, "R3 left high");
    check(ready == 1'b0, "R8 first read clears", ready, 0);
    rd_byte(1'b0, 8'h40, "R4 left low");
    check(ready == 1'b0, "R8 second read keeps", ready, 0);

    // R10: data holds while idle
    hold_rd = rd_data;
    repeat (3) @(negedge clk);
    check(rd_data == hold_rd, "R10 hold idle", rd_data, hold_rd);

    // right, ratiometric unsigned
    right_just = 1'b1; signed_sel = 1'b0;
    conv(10'h3A7, 2'd1);
    rd_byte(1'b0, 8'hA7, "R5 right low");
    rd_byte(1'b1, 8'h03, "R5 right high unsigned");

    // right, ratiometric signed
    signed_sel = 1'b1;
    conv(10'h3A7, 2'd1);
    rd_byte(1'b0, 8'hA7, "R6 right low signed");
    rd_byte(1'b1, 8'hFF, "R6 negative fill");
    conv(10'h15A, 2'd1);
    rd_byte(1'b0, 8'h5A, "R6 right low positive");
    rd_byte(1'b1, 8'h01, "R6 positive fill");

    // R7: sign ignored for absolute and temperature
    conv(10'h3A7, 2'd0);
    rd_byte(1'b0, 8'hA7, "R7 abs low");
    rd_byte(1'b1, 8'h03, "R7 abs high");
    conv(10'h2C1, 2'd2);
    rd_byte(1'b0, 8'hC1, "R7 temp low");
    rd_byte(1'b1, 8'h02, "R7 temp high");

    // R9: conversion between the two reads
    signed_sel = 1'b0;
    conv(10'h123, 2'd1);
    rd_byte(1'b0, 8'h23, "R9 first of old");
    conv(10'h2FF, 2'd1);
    check(ready == 1'b1, "R9 ready set again", ready, 1);
    rd_byte(1'b1, 8'h01, "R9 second keeps old");
    rd_byte(1'b0, 8'hFF, "R9 new low");
    rd_byte(1'b1, 8'h02, "R9 new high");

    // R8: second-byte read without a first read
    right_just = 1'b0;
    conv(10'h0F0, 2'd0);
    rd_byte(1'b0, 8'h02, "R8 stale shadow");
    check(ready == 1'b1, "R8 second read no clear", ready, 1);
    rd_byte(1'b1, 8'h3C, "R3 left high 2");
    rd_byte(1'b0, 8'h00, "R4 left low 2");

    // R11: done and first read in the same cycle
    @(negedge clk);
    exp_q.push_back(8'h3C); tag_q.push_back("R11 read returns old");
    done = 1'b1; code = 10'h3FE; kind = 2'd0;
    rd = 1'b1; rd_sel = 1'b1;
    @(negedge clk);
    done = 1'b0; rd = 1'b0;
    check(ready == 1'b1, "R11 ready stays set", ready, 1);
    rd_byte(1'b1, 8'hFF, "R11 new code high");
    rd_byte(1'b0, 8'h80, "R11 new code low");
    check(ready == 1'b0, "R8 cleared after R11", ready, 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads seen", exp_q.size(), 0);
    finish_run();
  end
endmodule